// File: doc/BRIEF.md
# Pipelined Merge-Exchange Sorter

This block sorts a vector of `N` unsigned words of `W` bits. `N` is a power of two, 16 by default, and words are 64 bits by default. The whole vector enters in parallel on one cycle under a valid strobe. After a fixed number of clocks the same words come out in ascending order, with a matching strobe.

The sorting network is built at elaboration from `N`. It follows the merge-exchange index schedule: an outer step size halves toward one, and each inner pass pairs position `i` with `i+d` wherever bit-field `(i AND p)` equals `r`. Each inner pass forms one network level. Levels are only partly filled, so the network uses fewer cells than levels × `N/2`: 19 cells for `N`=8, 63 for `N`=16 and 543 for `N`=64.

Each cell has one full-width unsigned magnitude comparator and a pair of 2:1 multiplexers. The smaller word always goes to the lower position. A register stage follows every level, so the critical path is a single cell, and a new vector may enter on every clock.

Top module: `msn_sorter`

## Requirements
- R1: When `out_valid` is high, the words of `out_data` are the words of the matching input vector in ascending order. Word `k` occupies bits `[k*W +: W]`, and word 0 holds the smallest value.
- R2: `out_valid` equals `in_valid` delayed by exactly L = lg N × (lg N + 1) / 2 clocks (10 clocks for N = 16). The data shown alongside it comes from that same input cycle.
- R3: Vectors presented on consecutive clocks each produce their own sorted output on consecutive clocks, with no gaps and no stalls.
- R4: While `rst_n` is low, and for L clocks after it is released with no valid input, `out_valid` is low. Reset is asynchronous and active low, and it clears every in-flight valid bit.
- R5: A cycle with `in_valid` low produces no output: `out_valid` is low L clocks later.
- R6: Duplicate values are all kept. A vector with repeated words, including one where all words are equal, comes out with the same number of copies of each value.
- R7: Comparison is unsigned. A word with bit `W-1` set sorts above every word with that bit clear.

Verification focuses on the failures that show up at the ports, and on how soon each one appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a vector to sort this cycle |
| in_data | input | N*W | Unsorted vector, word k at bits [k*W +: W] |
| out_valid | output | 1 | Marks `out_data` as a sorted vector |
| out_data | output | N*W | Sorted vector, word 0 smallest |

## Verification
A wrong pairing, a missing cell or an inverted comparator does not stay hidden. It shows up as an out-of-order or altered word in `out_data` exactly L clocks after the offending vector enters. Only vectors whose values expose that pair reveal it, which is why random, duplicate-heavy, sorted, reversed and top-bit-mixed vectors are all driven. A stage that drops or duplicates a valid bit shows up as an `out_valid` pulse one cycle early or late, or a missing one, against an independent delay model. A reset that fails to clear a stage shows up as a stray `out_valid` pulse within L clocks of release.

// File: rtl/msn_pkg.sv
package msn_pkg;

   // Number of network levels for a power-of-two width n.
   function automatic int msn_levels(input int n);
      int t;
      t = $clog2(n);
      return (t * (t + 1)) / 2;
   endfunction

   // Walk the merge-exchange schedule and return one field of level lvl.
   // sel: 0 = mask p, 1 = match r, 2 = distance d.
   function automatic int msn_sched(input int n, input int lvl, input int sel);
      int t, p, q, r, d, cnt;
      bit more;
      t   = $clog2(n);
      p   = 1 << (t - 1);
      cnt = 0;
      while (p > 0) begin
         q    = 1 << (t - 1);
         r    = 0;
         d    = p;
         more = 1'b1;
         while (more) begin
            if (cnt == lvl) begin
               if (sel == 0) return p;
               else if (sel == 1) return r;
               else return d;
            end
            cnt++;
            if (q != p) begin
               d = q - p;
               q = q / 2;
               r = p;
            end else begin
               more = 1'b0;
            end
         end
         p = p / 2;
      end
      return 0;
   endfunction

   // Total compare/exchange cells in the network for width n.
   function automatic int msn_cells(input int n);
      int total, lp, lr, ld;
      total = 0;
      for (int l = 0; l < msn_levels(n); l++) begin
         lp = msn_sched(n, l, 0);
         lr = msn_sched(n, l, 1);
         ld = msn_sched(n, l, 2);
         for (int i = 0; i + ld < n; i++)
            if ((i & lp) == lr) total++;
      end
      return total;
   endfunction

endpackage

// File: rtl/msn_cell.sv
module msn_cell #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;

   // Unsigned magnitude compare; equal words stay in place.
   assign swap = (a > b);
   assign lo   = swap ? b : a;
   assign hi   = swap ? a : b;
endmodule

// File: rtl/msn_level.sv
module msn_level #(
   parameter int N  = 16,
   parameter int W  = 64,
   parameter int LP = 1,
   parameter int LR = 0,
   parameter int LD = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [N-1:0][W-1:0] in_data,
   output logic                out_vld,
   output logic [N-1:0][W-1:0] out_data
);
   logic [W-1:0] nxt [N];
   logic [W-1:0] sum_in;
   logic [W-1:0] sum_out;

   for (genvar i = 0; i < N; i++) begin : g_pos
      localparam bit IS_LO = (i + LD < N) && ((i & LP) == LR);
      localparam bit IS_HI = (i >= LD) && (((i - LD) & LP) == LR);
      if (IS_LO) begin : g_cell
         msn_cell #(.W(W)) u_cell (
            .a  (in_data[i]),
            .b  (in_data[i+LD]),
            .lo (nxt[i]),
            .hi (nxt[i+LD])
         );
         // R1
         pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> (out_data[i] <= out_data[i+LD]));
      end else if (!IS_HI) begin : g_pass
         assign nxt[i] = in_data[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) out_data[i] <= nxt[i];
   end

   always_comb begin
      sum_in  = '0;
      sum_out = '0;
      for (int i = 0; i < N; i++) begin
         sum_in  = sum_in + in_data[i];
         sum_out = sum_out + out_data[i];
      end
   end

   // R6
   sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (sum_out == $past(sum_in)));

   // R2
   vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == $past(in_vld));
endmodule

// File: rtl/msn_sorter.sv
module msn_sorter
   import msn_pkg::*;
#(
   parameter int N = 16,
   parameter int W = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_data,
   output logic           out_valid,
   output logic [N*W-1:0] out_data
);
   localparam int LEVELS = msn_levels(N);
   localparam int CELLS  = msn_cells(N);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("msn_sorter: N must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("msn_sorter: W must be positive");
   end
   if ((N == 8 && CELLS != 19) || (N == 16 && CELLS != 63) ||
       (N == 64 && CELLS != 543)) begin : g_bad_sched
      $error("msn_sorter: schedule produced an unexpected cell count");
   end

   logic [N-1:0][W-1:0] stg_d [LEVELS+1];
   logic                stg_v [LEVELS+1];

   assign stg_d[0] = in_data;
   assign stg_v[0] = in_valid;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      msn_level #(
         .N  (N),
         .W  (W),
         .LP (msn_sched(N, l, 0)),
         .LR (msn_sched(N, l, 1)),
         .LD (msn_sched(N, l, 2))
      ) u_level (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_vld   (stg_v[l]),
         .in_data  (stg_d[l]),
         .out_vld  (stg_v[l+1]),
         .out_data (stg_d[l+1])
      );
   end

   assign out_data  = stg_d[LEVELS];
   assign out_valid = stg_v[LEVELS];

   logic ascending;
   always_comb begin
      ascending = 1'b1;
      for (int k = 0; k + 1 < N; k++)
         if (stg_d[LEVELS][k] > stg_d[LEVELS][k+1]) ascending = 1'b0;
   end

   // R1
   out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ascending);

   // R4
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !out_valid);
endmodule

// File: tb/msn_sorter_tb.sv
module msn_sorter_tb;
   localparam int N   = 16;
   localparam int W   = 64;
   localparam int LG  = $clog2(N);
   localparam int LEV = LG * (LG + 1) / 2;

   typedef logic [W-1:0] vec_t [N];

   // Stimulus plan: {pattern kind, vector count}.
   // 0 random, 1 duplicate-heavy, 2 ascending, 3 descending,
   // 4 all equal, 5 top-bit mix, 6 idle (in_valid low)
   localparam int PLAN [9][2] = '{
      '{6, 2}, '{0, 30}, '{6, 3}, '{1, 30}, '{2, 5},
      '{3, 5}, '{4, 3}, '{5, 20}, '{6, 12}};

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_valid;
   logic [N*W-1:0] in_data;
   logic           out_valid;
   logic [N*W-1:0] out_data;

   int checks = 0;
   int errors = 0;

   vec_t  mq_d [LEV];
   logic  mq_v [LEV];
   string mq_t [LEV];

   always #2 clk = ~clk;

   msn_sorter #(.N(N), .W(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   function automatic logic [N*W-1:0] pack(input vec_t v);
      logic [N*W-1:0] f;
      for (int k = 0; k < N; k++) f[k*W +: W] = v[k];
      return f;
   endfunction

   function automatic vec_t ref_sort(input vec_t v);
      vec_t s;
      logic [W-1:0] tmp;
      s = v;
      for (int a = 0; a < N; a++)
         for (int b = 0; b + 1 < N - a; b++)
            if (s[b] > s[b+1]) begin
               tmp = s[b]; s[b] = s[b+1]; s[b+1] = tmp;
            end
      return s;
   endfunction

   function automatic vec_t make_vec(input int kind);
      vec_t v;
      logic [W-1:0] base;
      base = {$urandom, $urandom};
      for (int k = 0; k < N; k++) begin
         case (kind)
            1: v[k] = W'($urandom_range(0, 3));
            2: v[k] = W'(k * 7 + 1);
            3: v[k] = W'((N - k) * 5);
            4: v[k] = base;
            5: begin
               v[k] = {$urandom, $urandom};
               v[k][W-1] = k[0];
            end
            default: v[k] = {$urandom, $urandom};
         endcase
      end
      return v;
   endfunction

   function automatic string kind_tag(input int kind);
      case (kind)
         1: return "R6 duplicates";
         2: return "R1 ascending";
         3: return "R1 descending";
         4: return "R6 all-equal";
         5: return "R7 unsigned";
         default: return "R1/R3 random";
      endcase
   endfunction

   task automatic clear_model();
      for (int j = 0; j < LEV; j++) begin
         mq_v[j] = 1'b0;
         mq_t[j] = "";
      end
   endtask

   task automatic check_out();
      checks++;
      if (out_valid !== mq_v[LEV-1]) begin
         errors++;
         $display("FAIL R2/R5 out_valid actual %b expected %b", out_valid, mq_v[LEV-1]);
      end
      if (mq_v[LEV-1]) begin
         checks++;
         if (out_data !== pack(mq_d[LEV-1])) begin
            errors++;
            $display("FAIL %s out_data actual %h expected %h",
                     mq_t[LEV-1], out_data, pack(mq_d[LEV-1]));
         end
      end
   endtask

   task automatic step(input logic v, input int kind);
      vec_t x;
      @(negedge clk);
      check_out();
      for (int j = LEV - 1; j > 0; j--) begin
         mq_v[j] = mq_v[j-1];
         mq_d[j] = mq_d[j-1];
         mq_t[j] = mq_t[j-1];
      end
      x        = make_vec(kind);
      in_valid = v;
      in_data  = pack(x);
      mq_v[0]  = v;
      mq_d[0]  = ref_sort(x);
      mq_t[0]  = kind_tag(kind);
   endtask

   task automatic reset_check(input string what);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R4 %s out_valid actual %b expected 0", what, out_valid);
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      clear_model();
      repeat (3) @(negedge clk);
      reset_check("during power-on reset");
      rst_n = 1'b1;

      // Table walk: back-to-back vectors of each pattern, idle gaps between.
      for (int e = 0; e < 9; e++)
         for (int c = 0; c < PLAN[e][1]; c++)
            step(PLAN[e][0] != 6, PLAN[e][0]);

      // R2: one isolated vector, surrounded by idle cycles, at exact latency.
      step(1'b1, 0);
      for (int c = 0; c < LEV + 2; c++) step(1'b0, 6);

      // R4: asynchronous reset while the pipeline is full.
      for (int c = 0; c < LEV / 2; c++) step(1'b1, 0);
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      clear_model();
      #1;
      reset_check("mid-stream reset");
      repeat (2) @(negedge clk);
      reset_check("held reset");
      rst_n = 1'b1;
      // R4/R5: nothing may emerge after release with idle input.
      for (int c = 0; c < LEV + 2; c++) step(1'b0, 6);

      // R3: long back-to-back run after reset, then drain.
      for (int c = 0; c < 40; c++) step(1'b1, c % 6);
      for (int c = 0; c < LEV + 1; c++) step(1'b0, 6);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule